// File: doc/BRIEF.md
# Load Value Predictor with Confidence Classes

This block guesses the value that a load instruction is about to return and grades how far that guess can be trusted. The caller presents a slot number made of the low-order bits of the load's instruction address. That slot reads two direct-mapped arrays in the same cycle. One array holds the value the slot last loaded. The other holds a small saturating confidence counter. There are no tags, so any loads whose addresses share those low bits also share the entries.

The lookup returns the stored value and a three-way class: skip (do not predict), predict (use the value and verify it), or constant (the load has matched often enough to be treated as invariant). When the load resolves, the caller sends the slot, the value that was predicted and the value that actually arrived. The block compares the two values. It moves the counter up on a match and down on a mismatch, saturating at both ends. It always writes the arrived value into the value array.

The counter array may be smaller than the value array. In that case it uses only the lowest bits of the slot, and several value entries share one counter.

Top module: `load_value_predictor`

## Requirements
- R1: After reset, every lookup returns class code 0 (skip) and value 0.
- R2: A lookup presented with `lk_valid` at a clock edge produces `pred_valid`=1 and its result after that edge. `pred_valid` is 0 after an edge where `lk_valid` was 0.
- R3: The value array is indexed by all VAL_IDX_W bits of the slot. A write to one slot is not seen by a lookup of a different slot.
- R4: The counter array is indexed by the low CONF_IDX_W bits of the slot. Slots equal in those bits share one counter.
- R5: With a 2-bit counter, counter values 0 and 1 give class code 0 (skip), 2 gives code 1 (predict) and 3 gives code 2 (constant).
- R6: An update whose predicted value equals its actual value raises the counter by one, holding at the maximum.
- R7: An update whose values differ lowers the counter by one, holding at zero without wrapping.
- R8: Every update writes the actual value into the slot's value entry, whether the prediction matched or not.
- R9: When a lookup and an update address the same slot at the same edge, the lookup returns the contents from before the update. The updated contents are returned from the next edge on.
- R10: With a 1-bit counter (CONF_W=1), counter 0 gives class code 0 (skip) and counter 1 gives code 2 (constant). Code 1 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_slot | input | VAL_IDX_W | Low instruction-address bits of the load being looked up |
| upd_valid | input | 1 | Resolution strobe |
| upd_slot | input | VAL_IDX_W | Slot of the resolving load |
| upd_pred_value | input | VAL_W | Value that was predicted for the load |
| upd_actual_value | input | VAL_W | Value the load actually returned |
| pred_valid | output | 1 | Lookup result is present |
| pred_value | output | VAL_W | Predicted value |
| pred_class | output | 2 | 0 skip, 1 predict, 2 constant |

## Verification
Every lookup result is due one edge after the lookup is presented. The bench drives inputs at the falling edge and reads the outputs at the next falling edge, so exactly one rising edge lies between stimulus and sample. An update changes the arrays at the edge where it is presented, and the bench observes that change through a separate lookup one cycle later. The same-slot collision case presents both requests in one cycle. The bench expects the old contents in that cycle and the new contents on the following lookup.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

  typedef enum logic [1:0] {
    CLS_SKIP    = 2'd0,
    CLS_PREDICT = 2'd1,
    CLS_CONST   = 2'd2
  } lvp_class_e;

endpackage

// File: rtl/lvp_value_table.sv
module lvp_value_table #(
  parameter int VAL_W     = 64,
  parameter int VAL_IDX_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [VAL_IDX_W-1:0] rd_idx,
  output logic [VAL_W-1:0]     rd_value,
  input  logic                 wr_en,
  input  logic [VAL_IDX_W-1:0] wr_idx,
  input  logic [VAL_W-1:0]     wr_value
);
  localparam int DEPTH = 1 << VAL_IDX_W;

  // Array body has no reset so it maps onto block RAM; a flop per entry
  // records whether the entry was ever written since reset.
  logic [VAL_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] seen_q;
  logic [VAL_W-1:0] ram_q;
  logic             seen_rd_q;

  // Read-first port: a same-edge write is not visible to this read.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_value;
    if (rd_en) ram_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q    <= '0;
      seen_rd_q <= 1'b0;
    end else begin
      if (rd_en) seen_rd_q <= seen_q[rd_idx];
      if (wr_en) seen_q[wr_idx] <= 1'b1;
    end
  end

  assign rd_value = seen_rd_q ? ram_q : '0;

  AST_WRITE_MARKS_SEEN: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> seen_q[$past(wr_idx)]); // R8

endmodule

// File: rtl/lvp_conf_table.sv
module lvp_conf_table
  import lvp_pkg::*;
#(
  parameter int CONF_W     = 2,
  parameter int CONF_IDX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [CONF_IDX_W-1:0] rd_idx,
  output lvp_class_e            rd_class,
  input  logic                  upd_en,
  input  logic [CONF_IDX_W-1:0] upd_idx,
  input  logic                  upd_hit
);
  localparam int              DEPTH   = 1 << CONF_IDX_W;
  localparam logic [CONF_W-1:0] CTR_MAX = {CONF_W{1'b1}};

  logic [CONF_W-1:0] ctr_q [DEPTH];
  logic [CONF_W-1:0] upd_cur;
  logic [CONF_W-1:0] upd_next;
  logic [CONF_W-1:0] rd_cur;
  lvp_class_e        rd_cls_d;
  lvp_class_e        cls_q;

  assign upd_cur = ctr_q[upd_idx];
  assign rd_cur  = ctr_q[rd_idx];

  always_comb begin
    upd_next = upd_cur;
    if (upd_hit) begin
      if (upd_cur != CTR_MAX) upd_next = upd_cur + 1'b1;
    end else begin
      if (upd_cur != '0) upd_next = upd_cur - 1'b1;
    end
  end

  generate
    if (CONF_W >= 2) begin : g_three_class
      always_comb begin
        if (rd_cur == CTR_MAX)              rd_cls_d = CLS_CONST;
        else if (rd_cur == CTR_MAX - 1'b1)  rd_cls_d = CLS_PREDICT;
        else                                rd_cls_d = CLS_SKIP;
      end
    end else begin : g_two_class
      always_comb rd_cls_d = (rd_cur == CTR_MAX) ? CLS_CONST : CLS_SKIP;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= '0;
      cls_q <= CLS_SKIP;
    end else begin
      if (rd_en)  cls_q <= rd_cls_d;
      if (upd_en) ctr_q[upd_idx] <= upd_next;
    end
  end

  assign rd_class = cls_q;

  AST_HIT_NEVER_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_hit) |=> ctr_q[$past(upd_idx)] >= $past(upd_cur)); // R6
  AST_MISS_NEVER_RAISES: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_hit) |=> ctr_q[$past(upd_idx)] <= $past(upd_cur)); // R7
  AST_CLASS_ENCODING: assert property (@(posedge clk) disable iff (rst)
    cls_q != 2'd3); // R5
  AST_ONE_BIT_NO_PREDICT: assert property (@(posedge clk) disable iff (rst)
    (CONF_W == 1) |-> cls_q != CLS_PREDICT); // R10

endmodule

// File: rtl/load_value_predictor.sv
module load_value_predictor
  import lvp_pkg::*;
#(
  parameter int VAL_W      = 64,
  parameter int VAL_IDX_W  = 10,
  parameter int CONF_IDX_W = 8,
  parameter int CONF_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lk_valid,
  input  logic [VAL_IDX_W-1:0] lk_slot,
  input  logic                 upd_valid,
  input  logic [VAL_IDX_W-1:0] upd_slot,
  input  logic [VAL_W-1:0]     upd_pred_value,
  input  logic [VAL_W-1:0]     upd_actual_value,
  output logic                 pred_valid,
  output logic [VAL_W-1:0]     pred_value,
  output logic [1:0]           pred_class
);
  // The counter table may be narrower; it keeps only the low slot bits.
  localparam int CI_W = (CONF_IDX_W < VAL_IDX_W) ? CONF_IDX_W : VAL_IDX_W;

  logic       upd_hit;
  logic       pred_valid_q;
  lvp_class_e cls;

  assign upd_hit = (upd_pred_value == upd_actual_value);

  lvp_value_table #(
    .VAL_W     (VAL_W),
    .VAL_IDX_W (VAL_IDX_W)
  ) u_values (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (lk_valid),
    .rd_idx   (lk_slot),
    .rd_value (pred_value),
    .wr_en    (upd_valid),
    .wr_idx   (upd_slot),
    .wr_value (upd_actual_value)
  );

  lvp_conf_table #(
    .CONF_W     (CONF_W),
    .CONF_IDX_W (CI_W)
  ) u_conf (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (lk_valid),
    .rd_idx   (lk_slot[CI_W-1:0]),
    .rd_class (cls),
    .upd_en   (upd_valid),
    .upd_idx  (upd_slot[CI_W-1:0]),
    .upd_hit  (upd_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) pred_valid_q <= 1'b0;
    else     pred_valid_q <= lk_valid;
  end

  assign pred_valid = pred_valid_q;
  assign pred_class = cls;

  AST_RESULT_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid); // R2
  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid); // R2
  AST_HELD_WITHOUT_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    (!lk_valid && !upd_valid && !$past(rst)) |=> $stable(pred_value)); // R3

endmodule

// File: tb/tb_load_value_predictor.sv
module tb_load_value_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [9:0]  lk_slot = '0;
  logic        upd_valid = 1'b0;
  logic [9:0]  upd_slot = '0;
  logic [63:0] upd_pred = '0;
  logic [63:0] upd_act = '0;
  logic        pv, pv2;
  logic [63:0] pval, pval2;
  logic [1:0]  pcls, pcls2;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  load_value_predictor dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_slot(lk_slot),
    .upd_valid(upd_valid), .upd_slot(upd_slot),
    .upd_pred_value(upd_pred), .upd_actual_value(upd_act),
    .pred_valid(pv), .pred_value(pval), .pred_class(pcls)
  );

  load_value_predictor #(.VAL_W(64), .VAL_IDX_W(4), .CONF_IDX_W(3), .CONF_W(1)) dut1b (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_slot(lk_slot[3:0]),
    .upd_valid(upd_valid), .upd_slot(upd_slot[3:0]),
    .upd_pred_value(upd_pred), .upd_actual_value(upd_act),
    .pred_valid(pv2), .pred_value(pval2), .pred_class(pcls2)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; result sampled at the next falling edge.
  task automatic lookup(input logic [9:0] s);
    @(negedge clk);
    lk_valid = 1'b1; lk_slot = s;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic update(input logic [9:0] s, input logic [63:0] p, input logic [63:0] a);
    @(negedge clk);
    upd_valid = 1'b1; upd_slot = s; upd_pred = p; upd_act = a;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  localparam logic [63:0] VX = 64'h1122_3344_5566_7788;
  localparam logic [63:0] VY = 64'hCAFE_0000_BEEF_0001;
  localparam logic [63:0] VZ = 64'h0F0F_0F0F_0F0F_0F0F;
  localparam logic [9:0]  SA = 10'd64;
  localparam logic [9:0]  SC = 10'd320; // same low 8 bits as SA

  task automatic t_reset();
    @(negedge clk);
    check("R2 idle", {63'd0, pv}, 64'd0);
    lookup(SA);
    check("R2 valid", {63'd0, pv}, 64'd1);
    check("R1 class", {62'd0, pcls}, 64'd0);
    check("R1 value", pval, 64'd0);
    @(negedge clk);
    check("R2 drop", {63'd0, pv}, 64'd0);
  endtask

  task automatic t_count_up();
    update(SA, VX, VX);   // ctr 1
    lookup(SA);
    check("R5 ctr1 skip", {62'd0, pcls}, 64'd0);
    check("R8 value", pval, VX);
    update(SA, VX, VX);   // ctr 2
    lookup(SA);
    check("R5 ctr2 predict", {62'd0, pcls}, 64'd1);
    update(SA, VX, VX);   // ctr 3
    lookup(SA);
    check("R5 ctr3 const", {62'd0, pcls}, 64'd2);
    update(SA, VX, VX);   // stays 3
    lookup(SA);
    check("R6 saturate high", {62'd0, pcls}, 64'd2);
  endtask

  task automatic t_shared_counter();
    lookup(SC);
    check("R3 other slot untouched", pval, 64'd0);
    update(SC, 64'd0, 64'hDEAD); // mismatch: shared ctr 3 -> 2
    lookup(SA);
    check("R4 shared ctr", {62'd0, pcls}, 64'd1);
    check("R3 own value", pval, VX);
    lookup(SC);
    check("R3 slot C value", pval, 64'hDEAD);
  endtask

  task automatic t_count_down();
    update(SA, VX, VY);   // ctr 1, value Y
    lookup(SA);
    check("R7 down skip", {62'd0, pcls}, 64'd0);
    check("R8 overwrite on miss", pval, VY);
    update(SA, VX, VY);   // 0
    update(SA, VX, VY);   // stays 0
    update(SA, VY, VY);   // 1
    update(SA, VY, VY);   // 2
    lookup(SA);
    check("R7 no wrap at zero", {62'd0, pcls}, 64'd1);
  endtask

  task automatic t_collision();
    @(negedge clk);
    lk_valid = 1'b1; lk_slot = SA;
    upd_valid = 1'b1; upd_slot = SA; upd_pred = VZ; upd_act = VZ; // ctr 2 -> 3
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    check("R9 old value", pval, VY);
    check("R9 old class", {62'd0, pcls}, 64'd1);
    lookup(SA);
    check("R9 new value", pval, VZ);
    check("R9 new class", {62'd0, pcls}, 64'd2);
  endtask

  task automatic t_one_bit();
    update(10'd5, 64'd1, 64'd2); // forces 0
    lookup(10'd5);
    check("R10 zero skip", {62'd0, pcls2}, 64'd0);
    update(10'd5, 64'd7, 64'd7);
    lookup(10'd5);
    check("R10 one const", {62'd0, pcls2}, 64'd2);
    check("R10 value", pval2, 64'd7);
    update(10'd5, 64'd7, 64'd7);
    lookup(10'd5);
    check("R10 saturate", {62'd0, pcls2}, 64'd2);
    update(10'd5, 64'd7, 64'd8);
    lookup(10'd5);
    check("R10 back to skip", {62'd0, pcls2}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count_up();
    t_shared_counter();
    t_count_down();
    t_collision();
    t_one_bit();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule